// File: doc/BRIEF.md
# Serial Port Baud and Transmit Clock Generator

This block derives the timing enables for a serial port from the system clock. A reloadable down-counter divides the system clock by a programmable divisor plus one, giving a rate tick. The receiver takes that tick as its base enable with no further division. A prescale stage divides the same tick by 16 (normal asynchronous), 8 (double-speed asynchronous) or 2 (synchronous) to form the transmitter enable.

In synchronous mode the external clock pin is either an output or an input. As an output (master), it carries the half-rate phase of the internal clock. As an input (slave), the pin is passed through a two-stage synchronizer and an edge detector. The edge pulse then replaces the internal tick as the source for both enables. A polarity input selects which pin edge counts. All outputs are one-cycle enables in the system clock domain.

Top module: `uclk_gen`

## Requirements
- R1: After reset the counter holds zero, so rx_en is high in the first cycle after reset is released (asynchronous mode), and tx_en and xck_out are low.
- R2: With no strobe, the counter counts down once per cycle and reloads with `divisor` on the cycle after it reaches zero. The internal tick (counter at zero) therefore repeats every `divisor`+1 cycles.
- R3: A high `div_lo_wr` at a clock edge loads the counter with `divisor` at that edge, whatever the count was. The next tick then comes `divisor`+1 cycles after that edge.
- R4: rx_en equals the selected clock source tick in every cycle, with no division. The source is the internal tick, except in synchronous slave mode (`sync_mode`=1, `pin_drive`=0), where it is the external edge pulse.
- R5: With `sync_mode`=0 and `dbl_speed`=0, tx_en is high on every 16th source tick.
- R6: With `sync_mode`=0 and `dbl_speed`=1, tx_en is high on every 8th source tick.
- R7: With `sync_mode`=1, tx_en is high on every 2nd source tick, whatever the value of `dbl_speed`.
- R8: In synchronous master mode (`sync_mode`=1, `pin_drive`=1), xck_out changes level after each internal tick. It is low after reset and is 1 on the ticks where tx_en is high. In every other mode, xck_out is 0.
- R9: In synchronous slave mode, each active edge on `xck_in` gives a one-cycle rx_en pulse. The pulse is visible after the third clock edge that samples the new pin level. With `clk_pol`=0 the active edge is rising; with `clk_pol`=1 it is falling. Internal ticks have no effect on rx_en in this mode.
- R10: tx_en is never high in a cycle where rx_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divisor | input | DIV_W | Divisor register value |
| div_lo_wr | input | 1 | Low-byte write strobe; reloads the counter |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| dbl_speed | input | 1 | Double-speed select for asynchronous mode |
| pin_drive | input | 1 | Clock pin direction: 1 = output (master), 0 = input (slave) |
| clk_pol | input | 1 | Active external edge: 0 = rising, 1 = falling |
| xck_in | input | 1 | Raw external clock pin level |
| tx_en | output | 1 | Transmitter clock enable |
| rx_en | output | 1 | Receiver base clock enable |
| xck_out | output | 1 | Clock pin output level |

## Verification
The slave-edge assertion assumes that `clk_pol` and the slave mode select are steady while an edge moves through the synchronizer. It also assumes that `xck_in` is low throughout reset, so the synchronizer flops and the pin agree from the first cycle. The stimulus changes inputs only on falling clock edges. It holds the pin low during reset. It changes the polarity only after the pin has been idle for several cycles. Its pin edges are spaced wider than the detector latency, so each edge gives its own pulse.

// File: rtl/uclk_pkg.sv
// uclk_pkg: shared constants and helpers for the serial clock generator.
// Assumes a 4-bit transmit prescaler, which covers the largest ratio (16).
package uclk_pkg;
    localparam int PRE_W = 4;

    // Terminal-count mask of the transmit prescaler for the selected mode
    function automatic logic [PRE_W-1:0] tx_mask(input logic sync_m, input logic dbl);
        if (sync_m)
            return 4'd1;
        else if (dbl)
            return 4'd7;
        else
            return 4'd15;
    endfunction
endpackage

// File: rtl/uclk_rate_cnt.sv
// uclk_rate_cnt: reloadable down-counter acting as the baud prescaler.
// Emits tick whenever the count is zero. Reloads on zero or on a strobe.
// Assumes divisor is stable except when software rewrites it.
module uclk_rate_cnt #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick,
    output logic [DIV_W-1:0] count
);
    logic [DIV_W-1:0] cnt_q;

    // Count down, reloading on strobe or on reaching zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload || cnt_q == '0)
            cnt_q <= divisor;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick  = (cnt_q == '0);
    assign count = cnt_q;
endmodule

// File: rtl/uclk_ext_sync.sv
// uclk_ext_sync: synchronizes the external clock pin and detects its active edge.
// Pulse appears SYNC_STAGES+1 clocks after the pin level is first sampled.
// Assumes SYNC_STAGES >= 2.
module uclk_ext_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic edge_pulse
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sreg;
    logic         prev_q;
    logic         pulse_q;
    logic         edge_hit;

    // Shift the raw pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg <= '0;
        else
            sreg <= {sreg[TOP-1:0], pin};
    end

    // Hold the previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sreg[TOP];
    end

    // Select the active edge according to polarity
    always_comb begin
        if (pol)
            edge_hit = prev_q & ~sreg[TOP];
        else
            edge_hit = sreg[TOP] & ~prev_q;
    end

    // Register the edge into a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= edge_hit;
    end

    assign edge_pulse = pulse_q;
endmodule

// File: rtl/uclk_tx_div.sv
// uclk_tx_div: free-running prescaler of source ticks that forms the transmit enable.
// The mask chooses the ratio (mask+1). Bit 0 gives the half-rate phase for the pin.
module uclk_tx_div
    import uclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic [PRE_W-1:0] mask,
    output logic             tx_en,
    output logic             phase
);
    logic [PRE_W-1:0] pc_q;

    // Advance the prescaler on each source tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (src_tick)
            pc_q <= pc_q + 1'b1;
    end

    assign tx_en = src_tick && ((pc_q & mask) == mask);
    assign phase = pc_q[0];
endmodule

// File: rtl/uclk_gen.sv
// uclk_gen: top of the serial clock generator. It selects the clock source
// (internal rate tick or synchronized pin edge), divides it for the transmitter
// and drives the clock pin in master mode. All outputs are enables in the clk domain.
module uclk_gen
    import uclk_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             div_lo_wr,
    input  logic             sync_mode,
    input  logic             dbl_speed,
    input  logic             pin_drive,
    input  logic             clk_pol,
    input  logic             xck_in,
    output logic             tx_en,
    output logic             rx_en,
    output logic             xck_out
);
    logic             int_tick;
    logic             ext_edge;
    logic             src_tick;
    logic             phase;
    logic             slave_m;
    logic             master_m;
    logic [DIV_W-1:0] rate_count;

    uclk_rate_cnt #(.DIV_W(DIV_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (div_lo_wr),
        .divisor (divisor),
        .tick    (int_tick),
        .count   (rate_count)
    );

    uclk_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (xck_in),
        .pol        (clk_pol),
        .edge_pulse (ext_edge)
    );

    // Decode the mode and pick the clock source
    always_comb begin
        slave_m  = sync_mode & ~pin_drive;
        master_m = sync_mode & pin_drive;
        src_tick = slave_m ? ext_edge : int_tick;
    end

    uclk_tx_div u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .mask     (tx_mask(sync_mode, dbl_speed)),
        .tx_en    (tx_en),
        .phase    (phase)
    );

    assign rx_en   = src_tick;
    assign xck_out = master_m & phase;
endmodule

// File: rtl/uclk_gen_chk.sv
// uclk_gen_chk: property checker for uclk_gen, attached by bind.
// Assumes xck_in is low during reset and that mode/polarity are steady across edges.
module uclk_gen_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] divisor,
    input logic             div_lo_wr,
    input logic             sync_mode,
    input logic             pin_drive,
    input logic             clk_pol,
    input logic             xck_in,
    input logic             tx_en,
    input logic             rx_en,
    input logic             xck_out,
    input logic [DIV_W-1:0] rate_count
);
    logic [2:0] up_cnt;

    // Count cycles since reset release, saturating, to guard deep $past use
    always_ff @(posedge clk) begin
        if (!rst_n)
            up_cnt <= '0;
        else if (up_cnt != 3'd7)
            up_cnt <= up_cnt + 1'b1;
    end

    assert_tx_within_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> rx_en);

    assert_strobe_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_lo_wr |=> (rate_count == $past(divisor)));

    assert_zero_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_count == '0 && !div_lo_wr) |=> (rate_count == $past(divisor)));

    assert_pin_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_mode && pin_drive) |-> !xck_out);

    assert_slave_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 3'd4 && rx_en && sync_mode && !pin_drive && !$past(clk_pol))
        |-> ($past(xck_in, 3) && !$past(xck_in, 4)));
endmodule

bind uclk_gen uclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .divisor    (divisor),
    .div_lo_wr  (div_lo_wr),
    .sync_mode  (sync_mode),
    .pin_drive  (pin_drive),
    .clk_pol    (clk_pol),
    .xck_in     (xck_in),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .xck_out    (xck_out),
    .rate_count (rate_count)
);

// File: tb/uclk_gen_bench.sv
module uclk_gen_bench;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] divisor = '0;
    logic          div_lo_wr = 1'b0;
    logic          sync_mode = 1'b0;
    logic          dbl_speed = 1'b0;
    logic          pin_drive = 1'b0;
    logic          clk_pol = 1'b0;
    logic          xck_in = 1'b0;
    logic          tx_en, rx_en, xck_out;

    int n_checks = 0;
    int n_fail = 0;

    // behavioural reference state
    int  m_cnt = 0;
    int  m_pc = 0;
    bit  m_edge = 0;
    bit  pin_hist[$];

    always #4 clk = ~clk;

    uclk_gen #(.DIV_W(DW)) u_uclk_gen (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .div_lo_wr(div_lo_wr),
        .sync_mode(sync_mode), .dbl_speed(dbl_speed), .pin_drive(pin_drive),
        .clk_pol(clk_pol), .xck_in(xck_in),
        .tx_en(tx_en), .rx_en(rx_en), .xck_out(xck_out)
    );

    function automatic bit exp_src();
        if (sync_mode && !pin_drive) return m_edge;
        return (m_cnt == 0);
    endfunction

    function automatic int ratio();
        if (sync_mode) return 2;
        if (dbl_speed) return 8;
        return 16;
    endfunction

    function automatic bit exp_tx();
        return exp_src() && ((m_pc % ratio()) == ratio() - 1);
    endfunction

    function automatic bit exp_xck();
        if (sync_mode && pin_drive) return (m_pc % 2) == 1;
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // reference model advanced on every rising edge
    always @(posedge clk) begin
        bit src;
        bit s2, s3;
        src = exp_src();
        pin_hist.push_front(rst_n ? xck_in : 1'b0);
        if (pin_hist.size() > 4) void'(pin_hist.pop_back());
        s2 = pin_hist[2];
        s3 = pin_hist[3];
        if (!rst_n) begin
            m_cnt  = 0;
            m_pc   = 0;
            m_edge = 0;
        end else begin
            m_edge = clk_pol ? (s3 && !s2) : (s2 && !s3);
            if (div_lo_wr || m_cnt == 0) m_cnt = int'(divisor);
            else m_cnt = m_cnt - 1;
            if (src) m_pc = (m_pc + 1) % 16;
        end
    end

    // compare against the model every cycle, after inputs settle
    always @(negedge clk) begin
        string ttag;
        #2;
        if (rst_n) begin
            ttag = sync_mode ? "R7" : (dbl_speed ? "R6" : "R5");
            check("R4", rx_en, exp_src());
            check(ttag, tx_en, exp_tx());
            check("R8", xck_out, exp_xck());
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_div(input int d);
        divisor   = DW'(d);
        div_lo_wr = 1'b1;
        @(negedge clk);
        div_lo_wr = 1'b0;
    endtask

    task automatic sample(output logic r, output logic t);
        #2;
        r = rx_en;
        t = tx_en;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic r, t;
        int   cnt_rx, cnt_tx;
        pin_hist = '{0, 0, 0, 0};
        cyc(5);
        rst_n = 1'b1;
        // R1: first cycle after reset shows a tick and no tx or pin output
        sample(r, t);
        check("R1", r, 1'b1);
        check("R1", xck_out, 1'b0);
        cyc(20);

        // R2: divisor 4 gives a tick every 5 cycles
        write_div(4);
        cnt_rx = 0;
        for (int i = 0; i < 50; i++) begin
            sample(r, t);
            if (r) cnt_rx++;
            @(negedge clk);
        end
        check("R2", cnt_rx == 10, 1'b1);

        // R5: normal asynchronous, count tx over 16 ticks
        cnt_tx = 0;
        for (int i = 0; i < 80; i++) begin
            sample(r, t);
            if (t) cnt_tx++;
            @(negedge clk);
        end
        check("R5", cnt_tx == 1, 1'b1);

        // R3: strobe mid-count restarts with the new divisor
        cyc(2);
        divisor   = DW'(9);
        div_lo_wr = 1'b1;
        @(negedge clk);
        div_lo_wr = 1'b0;
        for (int i = 0; i < 9; i++) begin
            sample(r, t);
            check("R3", r, 1'b0);
            @(negedge clk);
        end
        sample(r, t);
        check("R3", r, 1'b1);
        @(negedge clk);

        // R6: double-speed asynchronous
        dbl_speed = 1'b1;
        write_div(1);
        cyc(100);

        // R7 and R8: synchronous master
        sync_mode = 1'b1;
        pin_drive = 1'b1;
        write_div(2);
        cyc(60);
        dbl_speed = 1'b0;
        write_div(0);
        cyc(30);

        // R9: synchronous slave, rising edge active
        pin_drive = 1'b0;
        clk_pol   = 1'b0;
        divisor   = DW'(0);
        cyc(10);
        for (int k = 0; k < 6; k++) begin
            xck_in = 1'b1;
            @(negedge clk);
            sample(r, t);
            check("R9", r, 1'b0);
            @(negedge clk);
            sample(r, t);
            check("R9", r, 1'b0);
            @(negedge clk);
            sample(r, t);
            check("R9", r, 1'b1);
            @(negedge clk);
            sample(r, t);
            check("R9", r, 1'b0);
            cyc(4);
            xck_in = 1'b0;
            cyc(8);
        end

        // R9: falling edge active
        clk_pol = 1'b1;
        cyc(6);
        for (int k = 0; k < 6; k++) begin
            xck_in = 1'b1;
            cnt_rx = 0;
            for (int i = 0; i < 7; i++) begin
                @(negedge clk);
                sample(r, t);
                if (r) cnt_rx++;
            end
            check("R9", cnt_rx == 0, 1'b1);
            xck_in = 1'b0;
            cyc(9);
        end

        // R10 across a mode change back to asynchronous
        sync_mode = 1'b0;
        clk_pol   = 1'b0;
        write_div(3);
        for (int i = 0; i < 200; i++) begin
            sample(r, t);
            if (t) check("R10", r, 1'b1);
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule